// File: doc/BRIEF.md
# Cluster Majority Coincidence Trigger

This block forms the local trigger of one antenna cluster. Each of the twelve
discriminator hit lines is stretched by its own down-counter into an activity
window whose length, in clock cycles, comes from an input. While at least a
programmable number of stretched channels are active together, the block emits
a one-cycle level-1 trigger. The block records which channels were active in
that cycle. After each trigger, a holdoff equal to the window length keeps the
same burst of activity from firing the trigger again.

Each channel also runs a rate servo. Rising edges on the hit line are counted
over a fixed servo period. At the end of the period the count is compared with
a shared target. The channel's threshold code then steps up by one, steps down
by one or stays put, and it saturates at either end of its range. The
threshold codes drive external DACs. Raising a threshold is expected to lower
that channel's singles rate.

Top module: `cluster_coinc_trigger`

## Requirements
- R1: A hit seen at a clock edge keeps its channel active for the next `win_len_i` evaluation edges. Channels whose active spans overlap count together, and channels whose spans do not overlap do not.
- R2: When the condition holds at an evaluation edge, `trig_o` is high for exactly one cycle, starting from that edge.
- R3: The condition is "number of active channels >= `maj_i`". No trigger ever fires when `maj_i` is 0 or `win_len_i` is 0.
- R4: A trigger loads a holdoff of `win_len_i` cycles. No trigger fires at the next `win_len_i` evaluation edges. The first edge after that may fire again.
- R5: At a trigger, `pattern_o` (bit c = channel c) takes the active-channel set of the firing edge. It holds that value until the next trigger. It is 0 after reset.
- R6: Once every `SERVO_PERIOD` cycles (the first time at edge `SERVO_PERIOD` after reset), each channel compares its rising-edge count for the period with `target_i`. The threshold code goes +1 if the count is above the target, goes -1 if the count is below, and is unchanged if they are equal. The counts then restart.
- R7: A threshold code stays at 0 when told to go down, and stays at 2^THR_W-1 when told to go up.
- R8: After reset, `trig_o` is 0 and every threshold code is 2^(THR_W-1). Channel c's code sits at `thr_o[c*THR_W +: THR_W]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_i | input | NCH | Synchronised discriminator hits, one per channel |
| win_len_i | input | WIN_W | Coincidence window and holdoff length in cycles |
| maj_i | input | CNT_W | Minimum number of overlapping channels |
| target_i | input | RATE_W | Target hit count per servo period |
| trig_o | output | 1 | One-cycle trigger pulse |
| pattern_o | output | NCH | Active-channel set latched at the last trigger |
| thr_o | output | NCH*THR_W | Packed per-channel threshold codes |

## Verification
The bench aims at the edges of the window. Hits spaced two cycles apart must combine, and hits spaced past the window must not. An off-by-one in the stretcher would either merge the separated pair or split the close one. The holdoff test re-arms a second channel set while the holdoff is still running and expects the trigger exactly one cycle after the holdoff ends. A design that re-armed too early or too late would miss that cycle. The servo is driven into both saturation limits, and the bench checks all three step outcomes against their targets. A design that wrapped past a limit or stepped on an equal count would show a wrong code.

// File: rtl/cct_pkg.sv
package cct_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_t;

  // Decide the servo step from the comparison and the range limits.
  function automatic step_t servo_decide(input logic above, input logic below,
                                         input logic at_top, input logic at_bot);
    if (above && !at_top) return STEP_UP;
    if (below && !at_bot) return STEP_DOWN;
    return STEP_HOLD;
  endfunction

endpackage

// File: rtl/cct_stretcher.sv
module cct_stretcher #(
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic [WIN_W-1:0] win_len,
  output logic             active
);

  logic [WIN_W-1:0] remain;

  function automatic logic [WIN_W-1:0] next_remain(input logic h,
                                                   input logic [WIN_W-1:0] len,
                                                   input logic [WIN_W-1:0] cur);
    if (h) return len;
    if (cur != '0) return cur - 1'b1;
    return cur;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) remain <= '0;
    else        remain <= next_remain(hit, win_len, remain);
  end

  assign active = (remain != '0);

endmodule

// File: rtl/cct_majority.sv
module cct_majority #(
  parameter int NCH   = 12,
  parameter int WIN_W = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   active,
  input  logic [WIN_W-1:0] win_len,
  input  logic [CNT_W-1:0] maj,
  output logic             fire,
  output logic             hold_busy,
  output logic             trig,
  output logic [NCH-1:0]   pattern
);

  localparam int POP_W = $clog2(NCH + 1);

  logic [WIN_W-1:0] hold;
  logic [POP_W-1:0] pop;

  function automatic logic [POP_W-1:0] popcount(input logic [NCH-1:0] v);
    logic [POP_W-1:0] s;
    s = '0;
    for (int i = 0; i < NCH; i++) s = s + POP_W'(v[i]);
    return s;
  endfunction

  assign pop       = popcount(active);
  assign hold_busy = (hold != '0);
  assign fire      = (maj != '0) && (int'(pop) >= int'(maj)) && !hold_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold    <= '0;
      trig    <= 1'b0;
      pattern <= '0;
    end else begin
      trig <= fire;
      if (fire) begin
        hold    <= win_len;
        pattern <= active;
      end else if (hold_busy) begin
        hold <= hold - 1'b1;
      end
    end
  end

endmodule

// File: rtl/cct_servo.sv
module cct_servo
  import cct_pkg::*;
#(
  parameter int RATE_W = 10,
  parameter int THR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic              tick,
  input  logic [RATE_W-1:0] target,
  output logic [THR_W-1:0]  thr
);

  localparam logic [THR_W-1:0]  THR_MAX  = '1;
  localparam logic [THR_W-1:0]  THR_INIT = THR_W'(1) << (THR_W - 1);
  localparam logic [RATE_W-1:0] CNT_MAX  = '1;

  logic              hit_q;
  logic              rise;
  logic [RATE_W-1:0] cnt;
  step_t             step;

  assign rise = hit && !hit_q;
  assign step = servo_decide(cnt > target, cnt < target,
                             thr == THR_MAX, thr == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      cnt   <= '0;
      thr   <= THR_INIT;
    end else begin
      hit_q <= hit;
      if (tick) begin
        cnt <= RATE_W'(rise);
        case (step)
          STEP_UP:   thr <= thr + 1'b1;
          STEP_DOWN: thr <= thr - 1'b1;
          default:   thr <= thr;
        endcase
      end else if (rise && cnt != CNT_MAX) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/cluster_coinc_trigger.sv
module cluster_coinc_trigger #(
  parameter int NCH          = 12,
  parameter int WIN_W        = 8,
  parameter int CNT_W        = 4,
  parameter int RATE_W       = 10,
  parameter int THR_W        = 8,
  parameter int SERVO_PERIOD = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH-1:0]       hit_i,
  input  logic [WIN_W-1:0]     win_len_i,
  input  logic [CNT_W-1:0]     maj_i,
  input  logic [RATE_W-1:0]    target_i,
  output logic                 trig_o,
  output logic [NCH-1:0]       pattern_o,
  output logic [NCH*THR_W-1:0] thr_o
);

  localparam int PER_W = (SERVO_PERIOD > 1) ? $clog2(SERVO_PERIOD) : 1;

  logic [NCH-1:0]   active_w;
  logic             fire_w;
  logic             hold_busy_w;
  logic             servo_tick_w;
  logic [PER_W-1:0] per_cnt;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    cct_stretcher #(.WIN_W(WIN_W)) u_str (
      .clk(clk), .rst_n(rst_n), .hit(hit_i[c]),
      .win_len(win_len_i), .active(active_w[c])
    );
    cct_servo #(.RATE_W(RATE_W), .THR_W(THR_W)) u_srv (
      .clk(clk), .rst_n(rst_n), .hit(hit_i[c]), .tick(servo_tick_w),
      .target(target_i), .thr(thr_o[c*THR_W +: THR_W])
    );
  end

  cct_majority #(.NCH(NCH), .WIN_W(WIN_W), .CNT_W(CNT_W)) u_maj (
    .clk(clk), .rst_n(rst_n), .active(active_w), .win_len(win_len_i),
    .maj(maj_i), .fire(fire_w), .hold_busy(hold_busy_w),
    .trig(trig_o), .pattern(pattern_o)
  );

  assign servo_tick_w = (per_cnt == PER_W'(SERVO_PERIOD - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)            per_cnt <= '0;
    else if (servo_tick_w) per_cnt <= '0;
    else                   per_cnt <= per_cnt + 1'b1;
  end

endmodule

// File: rtl/cct_checker.sv
module cct_checker #(
  parameter int NCH   = 12,
  parameter int WIN_W = 8,
  parameter int CNT_W = 4,
  parameter int THR_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 trig_o,
  input logic [NCH-1:0]       pattern_o,
  input logic [WIN_W-1:0]     win_len_i,
  input logic [CNT_W-1:0]     maj_i,
  input logic [NCH*THR_W-1:0] thr_o,
  input logic                 servo_tick_w
);

  AST_TRIG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |=> !trig_o); // R2

  AST_HOLDOFF_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_o && $past(win_len_i) >= WIN_W'(2)) |=> (!trig_o ##1 !trig_o)); // R4

  AST_MAJ_MET: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> ($past(maj_i) != '0 && $countones(pattern_o) >= int'($past(maj_i)))); // R3

  AST_PATTERN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_o |-> $stable(pattern_o)); // R5

  for (genvar c = 0; c < NCH; c++) begin : g_thr
    AST_THR_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_o[c*THR_W +: THR_W] != $past(thr_o[c*THR_W +: THR_W])) |-> $past(servo_tick_w)); // R6
  end

endmodule

bind cluster_coinc_trigger cct_checker #(
  .NCH(NCH), .WIN_W(WIN_W), .CNT_W(CNT_W), .THR_W(THR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_o(trig_o), .pattern_o(pattern_o),
  .win_len_i(win_len_i), .maj_i(maj_i), .thr_o(thr_o),
  .servo_tick_w(servo_tick_w)
);

// File: tb/cluster_coinc_trigger_bench.sv
module cluster_coinc_trigger_bench;

  localparam int NCH = 12, WIN_W = 8, CNT_W = 4, RATE_W = 10, THR_W = 8;
  localparam int PER = 64;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [NCH-1:0]       hit_i = '0;
  logic [WIN_W-1:0]     win_len_i = 8'd4;
  logic [CNT_W-1:0]     maj_i = 4'd5;
  logic [RATE_W-1:0]    target_i = 10'd2;
  logic                 trig_o;
  logic [NCH-1:0]       pattern_o;
  logic [NCH*THR_W-1:0] thr_o;

  int checks = 0;
  int failures = 0;
  logic [NCH-1:0] last_pat;

  always #10 clk = ~clk;

  cluster_coinc_trigger #(
    .NCH(NCH), .WIN_W(WIN_W), .CNT_W(CNT_W), .RATE_W(RATE_W),
    .THR_W(THR_W), .SERVO_PERIOD(PER)
  ) u_cluster_coinc_trigger (.*);

  typedef struct packed {
    logic [NCH-1:0]   hits;
    logic [CNT_W-1:0] maj;
    logic             fires;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{12'h01F, 4'd5,  1'b1},
    '{12'h00F, 4'd5,  1'b0},
    '{12'hFFF, 4'd5,  1'b1},
    '{12'h7FF, 4'd12, 1'b0},
    '{12'hFFF, 4'd12, 1'b1},
    '{12'h800, 4'd1,  1'b1},
    '{12'h0A5, 4'd0,  1'b0},
    '{12'h555, 4'd6,  1'b1}
  };

  task automatic check(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int thr_of(input int c);
    return int'(thr_o[c*THR_W +: THR_W]);
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic watch_no_trig(input int n, input string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (trig_o) seen++;
    end
    check(seen, 0, req);
  endtask

  initial begin
    #4000000;
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    // R8 reset state
    check(int'(trig_o), 0, "R8 trig");
    check(int'(pattern_o), 0, "R5 reset pattern");
    check(thr_of(0), 128, "R8 thr0");
    check(thr_of(11), 128, "R8 thr11");

    // R6: ch0 5 edges, ch1 2 edges, others 0; target 2
    step(4);
    for (int k = 0; k < 10; k++) begin
      hit_i = '0;
      if (k % 2 == 0) begin
        if (k / 2 < 5) hit_i[0] = 1'b1;
        if (k / 2 < 2) hit_i[1] = 1'b1;
      end
      step(1);
    end
    hit_i = '0;
    step(50);
    check(thr_of(0), 129, "R6 above target up");
    check(thr_of(1), 128, "R6 equal target hold");
    check(thr_of(5), 127, "R6 below target down");

    // R7 low saturation
    target_i = 10'd1;
    step(131 * PER);
    check(thr_of(0), 0, "R7 floor ch0");
    check(thr_of(7), 0, "R7 floor ch7");

    // R7 high saturation
    target_i = 10'd0;
    for (int i = 0; i < 258 * PER; i++) begin
      hit_i = (i % 2 == 0) ? '1 : '0;
      step(1);
    end
    hit_i = '0;
    check(thr_of(3), 255, "R7 ceiling ch3");
    check(thr_of(10), 255, "R7 ceiling ch10");

    // Reset pattern tracking before trigger tests
    target_i = 10'd2;
    win_len_i = 8'd4;
    step(8);
    last_pat = pattern_o;

    // Table walk: R2 R3 R5
    foreach (VECS[v]) begin
      maj_i = VECS[v].maj;
      hit_i = VECS[v].hits;
      step(1);
      hit_i = '0;
      step(1);
      check(int'(trig_o), int'(VECS[v].fires), "R3 majority vector");
      if (VECS[v].fires) last_pat = VECS[v].hits;
      check(int'(pattern_o), int'(last_pat), "R5 latched pattern");
      step(1);
      check(int'(trig_o), 0, "R2 single cycle");
      step(8);
    end

    // R1 staggered inside window
    maj_i = 4'd5;
    hit_i = 12'h001; step(1);
    hit_i = '0;      step(1);
    hit_i = 12'h01E; step(1);
    hit_i = '0;      step(1);
    check(int'(trig_o), 1, "R1 overlap inside window");
    check(int'(pattern_o), 12'h01F, "R1 overlap pattern");
    step(10);

    // R1 staggered beyond window
    hit_i = 12'h001; step(1);
    hit_i = '0;      step(4);
    hit_i = 12'h01E; step(1);
    hit_i = '0;
    watch_no_trig(10, "R1 no overlap");

    // R4 holdoff then refire
    hit_i = 12'h01F; step(1);
    hit_i = '0;      step(1);
    check(int'(trig_o), 1, "R4 first trigger");
    hit_i = 12'h3E0; step(1);
    hit_i = '0;      step(1);
    check(int'(trig_o), 0, "R4 held j+3");
    step(1); check(int'(trig_o), 0, "R4 held j+4");
    step(1); check(int'(trig_o), 0, "R4 held j+5");
    step(1); check(int'(trig_o), 1, "R4 refire after holdoff");
    check(int'(pattern_o), 12'h3E0, "R5 second pattern");
    step(10);

    // R3 zero window never fires
    win_len_i = 8'd0;
    maj_i = 4'd1;
    hit_i = '1; step(3);
    hit_i = '0;
    watch_no_trig(6, "R3 zero window");
    check(int'(pattern_o), 12'h3E0, "R5 pattern kept");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule